// File: doc/BRIEF.md
# Time Slot Interchange Switching Core

This block is a small non-blocking time slot interchange for a few byte-wide TDM streams. Every clock is one channel period. In that cycle each receive stream delivers the byte of the current channel, and the byte is stored in a data memory indexed by frame bank, stream and channel. For each output stream and channel, a connection memory entry decides what the transmit side sends in that slot. The choices are a stored byte read with low latency, a stored byte read with a fixed two-frame delay, a byte supplied by the host, a test pattern byte, or nothing at all (the slot is not driven).

Three frame banks rotate at every frame boundary, so both delay flavours always have a stable source. A host write port updates connection memory entries and a small control register while traffic runs. A global drive enable combines a pin with a standby bit. A bypass mode routes each receive stream to the transmit stream of the same index and skips all switching. Bit-level serial framing, the pattern generator and the host bus protocol are left to surrounding logic.

Top module: `tsi_switch_core`

## Requirements
- R1: `slot_o` starts at 0 after reset and advances by one each clock, wrapping from NCHAN-1 to 0 (one frame = NCHAN clocks). The bytes on `rx_data_i` belong to channel `slot_o`. The outputs presented in the following cycle belong to that same channel.
- R2: While `rst` is high and in the cycle after it falls, `slot_o` is 0, `tx_oe_o` is all zero and `tx_data_o` is zero. Reset sets every connection memory mode to 111 and clears the bypass and standby bits.
- R3: The mode field of an entry is decoded as 000 variable delay, 001 constant delay, 100 host byte, 101 pattern slot. 111 and every other code leave the slot undriven: its `tx_oe_o` bit is 0 and its byte is 0.
- R4: In host byte mode, bits 7:0 of the entry's low word are sent in that slot every frame until the entry is rewritten.
- R5: In either delay mode, the low word selects the source: bits 4:0 give the channel and bits 6:5 give the stream. Several output slots may name the same source.
- R6: In constant delay mode, a byte received in frame n is sent in frame n+2.
- R7: In variable delay mode, the byte of the current frame is sent when the output channel is at least the source channel plus 3. Otherwise the byte of the previous frame is sent.
- R8: In pattern mode, the slot sends the value on `pat_i` in the cycle of that slot.
- R9: When `ode_i` and the standby bit are both 0, every `tx_oe_o` bit is 0 and `tx_data_o` is 0. When either one is 1, the slots drive as their modes say.
- R10: With the bypass bit set, stream s sends the byte received on stream s in the same slot, and every `tx_oe_o` bit follows the global enable of R9, whatever the connection memory holds.
- R11: `cm_waddr_i` is {stream[6:5], channel[4:0]} and `cm_wdata_i` is {mode[17:15], low word[14:0]}. A write takes effect at the next read of that slot, so a write made in the slot's own cycle first shows in the following frame. Control writes (`ctl_wdata_i` bit 0 standby, bit 1 bypass) take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_data_i | input | 32 | Receive bytes, stream s at bits [8s+7:8s] |
| pat_i | input | 8 | Test pattern byte for pattern slots |
| ode_i | input | 1 | Output drive enable pin |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 2 | Bit 1 bypass, bit 0 standby |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_waddr_i | input | 7 | {stream, channel} of the entry |
| cm_wdata_i | input | 18 | {mode, low word} |
| slot_o | output | 5 | Channel carried by `rx_data_i` this cycle |
| tx_data_o | output | 32 | Transmit bytes, stream s at bits [8s+7:8s] |
| tx_oe_o | output | 4 | Per-stream drive indication for the current slot |

## Verification
The assertions assume that the host writes the control register and the connection memory only through their strobes. They also assume that `rx_data_i`, `ode_i` and `pat_i` are stable around the clock edge. The bench changes every input half a period away from the rising edge, so these assumptions hold. The data memory powers up undefined, so checks of delayed reads are held back until the model frame count shows that the source bank was filled. The stimulus keeps one write per strobe and uses only the documented field positions.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int MODE_W = 3;
  localparam int LOW_W  = 15;
  localparam int BYTE_W = 8;
  localparam int NBANK  = 3;
  localparam int BANK_W = 2;

  localparam logic [MODE_W-1:0] MODE_VAR   = 3'b000;
  localparam logic [MODE_W-1:0] MODE_CONST = 3'b001;
  localparam logic [MODE_W-1:0] MODE_HOST  = 3'b100;
  localparam logic [MODE_W-1:0] MODE_PAT   = 3'b101;
  localparam logic [MODE_W-1:0] MODE_OFF   = 3'b111;
endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
  import tsi_pkg::*;
#(
  parameter int NCHAN = 32,
  localparam int CH_W = $clog2(NCHAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  output logic [CH_W-1:0]   slot_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              bypass_q,
  output logic              osb_q
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NCHAN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      bank_q   <= '0;
      bypass_q <= 1'b0;
      osb_q    <= 1'b0;
    end else begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      if (slot_q == LAST)
        bank_q <= (bank_q == BANK_W'(NBANK - 1)) ? '0 : bank_q + 1'b1;
      if (ctl_we) begin
        bypass_q <= ctl_wdata[1];
        osb_q    <= ctl_wdata[0];
      end
    end
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  localparam int ST_W = $clog2(NSTREAM),
  localparam int CH_W = $clog2(NCHAN)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [ST_W+CH_W-1:0]               waddr,
  input  logic [MODE_W+LOW_W-1:0]            wdata,
  input  logic [CH_W-1:0]                    slot,
  output logic [NSTREAM-1:0][MODE_W-1:0]     rd_mode,
  output logic [NSTREAM-1:0][LOW_W-1:0]      rd_low
);
  logic [MODE_W-1:0] mode_mem [NSTREAM][NCHAN];
  logic [LOW_W-1:0]  low_mem  [NSTREAM][NCHAN];

  logic [ST_W-1:0] w_st;
  logic [CH_W-1:0] w_ch;
  assign w_st = waddr[CH_W +: ST_W];
  assign w_ch = waddr[CH_W-1:0];

  // Mode field resets so that every slot starts undriven.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSTREAM; s++)
        for (int c = 0; c < NCHAN; c++)
          mode_mem[s][c] <= MODE_OFF;
    end else if (we) begin
      mode_mem[w_st][w_ch] <= wdata[LOW_W +: MODE_W];
    end
  end

  // Low word has no reset and maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (we) low_mem[w_st][w_ch] <= wdata[LOW_W-1:0];
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
    assign rd_mode[s] = mode_mem[s][slot];
    assign rd_low[s]  = low_mem[s][slot];
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  localparam int ST_W = $clog2(NSTREAM),
  localparam int CH_W = $clog2(NCHAN)
) (
  input  logic                             clk,
  input  logic [NSTREAM*BYTE_W-1:0]        wr_bytes,
  input  logic [BANK_W-1:0]                wr_bank,
  input  logic [CH_W-1:0]                  wr_chan,
  input  logic [NSTREAM-1:0][ST_W-1:0]     rd_strm,
  input  logic [NSTREAM-1:0][BANK_W-1:0]   rd_bank,
  input  logic [NSTREAM-1:0][CH_W-1:0]     rd_chan,
  output logic [NSTREAM-1:0][BYTE_W-1:0]   rd_byte
);
  logic [BYTE_W-1:0] dm [NSTREAM][NBANK][NCHAN];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTREAM; s++)
      dm[s][wr_bank][wr_chan] <= wr_bytes[s*BYTE_W +: BYTE_W];
  end

  for (genvar o = 0; o < NSTREAM; o++) begin : g_rd
    assign rd_byte[o] = dm[rd_strm[o]][rd_bank[o]][rd_chan[o]];
  end
endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  parameter int VAR_GAP = 3,
  localparam int ST_W = $clog2(NSTREAM),
  localparam int CH_W = $clog2(NCHAN),
  localparam int CMP_W = CH_W + 2 + $clog2(VAR_GAP + 1)
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [LOW_W-1:0]  low,
  input  logic [CH_W-1:0]   slot,
  input  logic [BANK_W-1:0] wbank,
  input  logic [BYTE_W-1:0] dm_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] pat,
  input  logic              bypass,
  input  logic              en,
  output logic [ST_W-1:0]   rd_strm,
  output logic [BANK_W-1:0] rd_bank,
  output logic [CH_W-1:0]   rd_chan,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_oe
);
  logic [BANK_W-1:0] prev_bank, oldest_bank;
  logic              src_done;
  logic              unused_low;

  assign unused_low  = ^low;
  assign rd_chan     = low[CH_W-1:0];
  assign rd_strm     = low[CH_W +: ST_W];
  assign prev_bank   = (wbank == '0) ? BANK_W'(NBANK - 1) : wbank - 1'b1;
  assign oldest_bank = (wbank == BANK_W'(NBANK - 1)) ? '0 : wbank + 1'b1;
  assign src_done    = CMP_W'(slot) >= (CMP_W'(rd_chan) + CMP_W'(VAR_GAP));
  assign rd_bank     = (mode == MODE_CONST) ? oldest_bank :
                       (src_done ? wbank : prev_bank);

  always_comb begin
    tx_byte = '0;
    tx_oe   = 1'b0;
    if (bypass) begin
      tx_byte = rx_byte;
      tx_oe   = 1'b1;
    end else begin
      unique case (mode)
        MODE_VAR, MODE_CONST: begin tx_byte = dm_byte;           tx_oe = 1'b1; end
        MODE_HOST:            begin tx_byte = low[BYTE_W-1:0];   tx_oe = 1'b1; end
        MODE_PAT:             begin tx_byte = pat;               tx_oe = 1'b1; end
        default:              begin tx_byte = '0;                tx_oe = 1'b0; end
      endcase
    end
    if (!en) begin
      tx_byte = '0;
      tx_oe   = 1'b0;
    end
  end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  parameter int VAR_GAP = 3
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [NSTREAM*8-1:0]                      rx_data_i,
  input  logic [7:0]                                pat_i,
  input  logic                                      ode_i,
  input  logic                                      ctl_we_i,
  input  logic [1:0]                                ctl_wdata_i,
  input  logic                                      cm_we_i,
  input  logic [$clog2(NSTREAM)+$clog2(NCHAN)-1:0]  cm_waddr_i,
  input  logic [17:0]                               cm_wdata_i,
  output logic [$clog2(NCHAN)-1:0]                  slot_o,
  output logic [NSTREAM*8-1:0]                      tx_data_o,
  output logic [NSTREAM-1:0]                        tx_oe_o
);
  localparam int ST_W = $clog2(NSTREAM);
  localparam int CH_W = $clog2(NCHAN);

  logic [CH_W-1:0]   slot_q;
  logic [BANK_W-1:0] bank_q;
  logic              bypass_q, osb_q, drive_en;

  logic [NSTREAM-1:0][MODE_W-1:0] cm_mode;
  logic [NSTREAM-1:0][LOW_W-1:0]  cm_low;
  logic [NSTREAM-1:0][ST_W-1:0]   rd_strm;
  logic [NSTREAM-1:0][BANK_W-1:0] rd_bank;
  logic [NSTREAM-1:0][CH_W-1:0]   rd_chan;
  logic [NSTREAM-1:0][BYTE_W-1:0] rd_byte;
  logic [NSTREAM*BYTE_W-1:0]      tx_data_d, tx_data_q;
  logic [NSTREAM-1:0]             tx_oe_d, tx_oe_q;

  assign drive_en = ode_i | osb_q;

  tsi_frame_ctl #(.NCHAN(NCHAN)) u_frame (
    .clk(clk), .rst(rst), .ctl_we(ctl_we_i), .ctl_wdata(ctl_wdata_i),
    .slot_q(slot_q), .bank_q(bank_q), .bypass_q(bypass_q), .osb_q(osb_q)
  );

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_cm (
    .clk(clk), .rst(rst), .we(cm_we_i), .waddr(cm_waddr_i), .wdata(cm_wdata_i),
    .slot(slot_q), .rd_mode(cm_mode), .rd_low(cm_low)
  );

  tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_dm (
    .clk(clk), .wr_bytes(rx_data_i), .wr_bank(bank_q), .wr_chan(slot_q),
    .rd_strm(rd_strm), .rd_bank(rd_bank), .rd_chan(rd_chan), .rd_byte(rd_byte)
  );

  for (genvar o = 0; o < NSTREAM; o++) begin : g_out
    tsi_out_sel #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .VAR_GAP(VAR_GAP)) u_sel (
      .mode(cm_mode[o]), .low(cm_low[o]), .slot(slot_q), .wbank(bank_q),
      .dm_byte(rd_byte[o]), .rx_byte(rx_data_i[o*BYTE_W +: BYTE_W]),
      .pat(pat_i), .bypass(bypass_q), .en(drive_en),
      .rd_strm(rd_strm[o]), .rd_bank(rd_bank[o]), .rd_chan(rd_chan[o]),
      .tx_byte(tx_data_d[o*BYTE_W +: BYTE_W]), .tx_oe(tx_oe_d[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_q <= '0;
      tx_oe_q   <= '0;
    end else begin
      tx_data_q <= tx_data_d;
      tx_oe_q   <= tx_oe_d;
    end
  end

  assign slot_o    = slot_q;
  assign tx_data_o = tx_data_q;
  assign tx_oe_o   = tx_oe_q;
endmodule

// File: rtl/tsi_switch_core_chk.sv
module tsi_switch_core_chk #(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  localparam int CH_W = $clog2(NCHAN)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ode_i,
  input logic                 osb_q,
  input logic                 bypass_q,
  input logic [NSTREAM*8-1:0] rx_data_i,
  input logic [CH_W-1:0]      slot_o,
  input logic [NSTREAM*8-1:0] tx_data_o,
  input logic [NSTREAM-1:0]   tx_oe_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NCHAN - 1);

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_o == LAST) |=> (slot_o == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_o != LAST) |=> (slot_o == CH_W'($past(slot_o) + 1'b1)));

  // R2
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (slot_o == '0 && tx_oe_o == '0 && tx_data_o == '0));

  // R9
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ode_i && !osb_q) |=> (tx_oe_o == '0 && tx_data_o == '0));

  // R10
  bypass_route_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass_q && (ode_i || osb_q)) |=>
      (tx_data_o == $past(rx_data_i) && tx_oe_o == {NSTREAM{1'b1}}));

  for (genvar s = 0; s < NSTREAM; s++) begin : g_quiet
    // R3
    quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
      !tx_oe_o[s] |-> (tx_data_o[s*8 +: 8] == 8'd0));
  end
endmodule

bind tsi_switch_core tsi_switch_core_chk #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst(rst), .ode_i(ode_i), .osb_q(osb_q), .bypass_q(bypass_q),
  .rx_data_i(rx_data_i), .slot_o(slot_o), .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o)
);

// File: tb/tsi_switch_core_bench.sv
module tsi_switch_core_bench;
  localparam int NS = 4;
  localparam int NC = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS*8-1:0] rx_data_i = '0;
  logic [7:0]    pat_i = '0;
  logic          ode_i = 1'b0;
  logic          ctl_we_i = 1'b0;
  logic [1:0]    ctl_wdata_i = '0;
  logic          cm_we_i = 1'b0;
  logic [6:0]    cm_waddr_i = '0;
  logic [17:0]   cm_wdata_i = '0;
  logic [4:0]    slot_o;
  logic [NS*8-1:0] tx_data_o;
  logic [NS-1:0] tx_oe_o;

  tsi_switch_core #(.NSTREAM(NS), .NCHAN(NC), .VAR_GAP(3)) u_tsi_switch_core (
    .clk(clk), .rst(rst), .rx_data_i(rx_data_i), .pat_i(pat_i), .ode_i(ode_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .cm_we_i(cm_we_i),
    .cm_waddr_i(cm_waddr_i), .cm_wdata_i(cm_wdata_i), .slot_o(slot_o),
    .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // bench model
  int frame_m = 0, slot_m = 0;
  bit bypass_m = 0, osb_m = 0, ode_v = 0;
  logic [2:0]  cm_mode_m [NS][NC];
  logic [14:0] cm_low_m  [NS][NC];
  bit          have_exp = 0;
  int          exp_slot;
  logic [7:0]  exp_d [NS];
  bit          exp_oe [NS];
  bit          exp_ck [NS];
  string       exp_tag [NS];
  string       cur_tag = "";

  bit          p_cm = 0, p_ctl = 0;
  int          p_s, p_c;
  logic [2:0]  p_mode;
  logic [14:0] p_low;
  logic [1:0]  p_ctlv;

  function automatic logic [7:0] rxv(int f, int s, int c);
    return 8'((f * 53 + s * 71 + c * 13 + 7) % 256);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (frame %0d slot %0d)",
               tag, what, act, expv, frame_m, slot_m);
    end
  endtask

  task automatic tick();
    int ss, sc, f;
    bit en;
    logic [2:0] md;
    logic [14:0] lw;
    if (have_exp) begin
      // R1: slot counter follows the bench count
      check(slot_o == 5'(slot_m), "R1", slot_o, slot_m, "slot");
      for (int s = 0; s < NS; s++) if (exp_ck[s]) begin
        check(tx_oe_o[s] == exp_oe[s], exp_tag[s], tx_oe_o[s], exp_oe[s], "oe");
        check(tx_data_o[s*8 +: 8] == exp_d[s], exp_tag[s], tx_data_o[s*8 +: 8], exp_d[s], "data");
      end
    end
    for (int s = 0; s < NS; s++) rx_data_i[s*8 +: 8] = rxv(frame_m, s, slot_m);
    pat_i       = 8'((cyc * 29 + 3) % 256);
    ode_i       = ode_v;
    ctl_we_i    = p_ctl;
    ctl_wdata_i = p_ctlv;
    cm_we_i     = p_cm;
    cm_waddr_i  = {2'(p_s), 5'(p_c)};
    cm_wdata_i  = {p_mode, p_low};
    en = ode_v | osb_m;
    for (int s = 0; s < NS; s++) begin
      md = cm_mode_m[s][slot_m];
      lw = cm_low_m[s][slot_m];
      exp_ck[s] = 1; exp_d[s] = 0; exp_oe[s] = 0;
      ss = int'(lw[6:5]); sc = int'(lw[4:0]);
      if (bypass_m) begin
        exp_tag[s] = "R10"; exp_d[s] = rxv(frame_m, s, slot_m); exp_oe[s] = 1;
      end else begin
        case (md)
          3'b000: begin
            exp_tag[s] = "R5,R7";
            f = (slot_m >= sc + 3) ? frame_m : frame_m - 1;
            if (f < 0) exp_ck[s] = 0; else exp_d[s] = rxv(f, ss, sc);
            exp_oe[s] = 1;
          end
          3'b001: begin
            exp_tag[s] = "R5,R6";
            f = frame_m - 2;
            if (f < 0) exp_ck[s] = 0; else exp_d[s] = rxv(f, ss, sc);
            exp_oe[s] = 1;
          end
          3'b100: begin exp_tag[s] = "R4"; exp_d[s] = lw[7:0]; exp_oe[s] = 1; end
          3'b101: begin exp_tag[s] = "R8"; exp_d[s] = pat_i;   exp_oe[s] = 1; end
          default: exp_tag[s] = "R3";
        endcase
      end
      if (!en) begin exp_d[s] = 0; exp_oe[s] = 0; exp_tag[s] = "R9"; end
      if (cur_tag != "") exp_tag[s] = cur_tag;
    end
    if (p_cm) begin cm_mode_m[p_s][p_c] = p_mode; cm_low_m[p_s][p_c] = p_low; end
    if (p_ctl) begin bypass_m = p_ctlv[1]; osb_m = p_ctlv[0]; end
    p_cm = 0; p_ctl = 0;
    have_exp = 1;
    cyc++;
    slot_m++;
    if (slot_m == NC) begin slot_m = 0; frame_m++; end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cm_write(int s, int c, logic [2:0] md, logic [14:0] lw);
    p_cm = 1; p_s = s; p_c = c; p_mode = md; p_low = lw;
    tick();
  endtask

  task automatic ctl_write(logic [1:0] v);
    p_ctl = 1; p_ctlv = v;
  endtask

  function automatic logic [2:0] mode_of(int o, int c);
    case ((o * 5 + c) % 7)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b100;
      3: return 3'b101;
      4: return 3'b111;
      5: return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  initial begin
    logic [14:0] lw;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin cm_mode_m[s][c] = 3'b111; cm_low_m[s][c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset values visible before the first active edge
    check(slot_o == 0, "R2", slot_o, 0, "slot after reset");
    check(tx_oe_o == 0, "R2", tx_oe_o, 0, "oe after reset");
    check(tx_data_o == 0, "R2", tx_data_o, 0, "data after reset");

    // R2: every entry reset to undriven, seen with the pin enabled
    ode_v = 1; cur_tag = "R2";
    run(NC);
    cur_tag = "";

    // program all entries with the pin low (R9 all quiet)
    ode_v = 0;
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < NC; c++) begin
        if (mode_of(o, c) == 3'b100) lw = 15'((o * 40 + c * 3 + 11) % 256);
        else if (c % 8 == 4) lw = {8'h00, 2'd2, 5'd9};   // shared source (R5)
        else lw = {8'h00, 2'((o + c) % 4), 5'((c * 7 + o * 3) % 32)};
        cm_write(o, c, mode_of(o, c), lw);
      end

    // main switching sweep
    ode_v = 1;
    run(4 * NC);

    // standby bit enables outputs with the pin low
    ode_v = 0; ctl_write(2'b01);
    run(NC);

    // bypass with enable, then with everything off
    ode_v = 1; ctl_write(2'b10);
    run(NC);
    ode_v = 0;
    run(NC);

    // R11: live rewrite of stream 0 in each slot's own cycle
    ode_v = 1; ctl_write(2'b00);
    tick();
    cur_tag = "R11";
    for (int i = 0; i < NC; i++)
      cm_write(0, slot_m, 3'b100, 15'((slot_m * 9 + 100) % 256));
    run(NC);
    cur_tag = "";
    run(NC);

    // R7 boundary: source 3 channels back versus 2 channels back
    for (int c = 0; c < NC; c++) cm_write(0, c, 3'b000, {8'h00, 2'd1, 5'((c + NC - 3) % NC)});
    for (int c = 0; c < NC; c++) cm_write(1, c, 3'b000, {8'h00, 2'd1, 5'((c + NC - 2) % NC)});
    run(2 * NC);
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule